// File: doc/BRIEF.md
# Prioritized Register-File Write Arbiter

This block lets three execution pipelines share a register file that has a single write port. Each cycle, every pipeline may present a write-back, made of a valid flag, a register index and a data word. The block picks one write for the port and keeps the others in a small holding queue. When the queue is empty, the highest-priority valid pipeline writes the array directly. When the queue holds anything, its oldest entry takes the port and every arriving write-back joins the queue. A pipeline is stalled only when the queue cannot take its result.

Pipeline 0 has the highest priority and pipeline 2 the lowest. Write-backs that are accepted in the same cycle count as older the higher their priority. Two combinational read ports look up the queue first and return the youngest queued value for the index. If the queue has nothing for that index, they return the array contents. The array is not cleared by reset. Reset empties the queue.

Top module: `rf_wb_arbiter`

## Requirements
- R1: With the queue empty, the valid pipeline with the smallest number is written into the array at the next clock edge, is not stalled, and is visible on the read ports from the following cycle.
- R2: With the queue empty, no pipeline is stalled. Every valid pipeline other than the direct writer is appended to the queue in priority order.
- R3: With the queue non-empty, its oldest entry is written to the array that cycle, and every accepted write-back of that cycle is appended to the queue.
- R4: With the queue non-empty and holding N of its 4 entries, 4-N+1 slots are offered, counting the entry being drained. Valid pipelines take them in order 0, 1, 2, and each valid pipeline left without a slot sees its stall bit at 1. Pipeline 0 is never stalled.
- R5: A stalled pipeline keeps its valid, index and data unchanged. Its write-back counts as accepted in the first cycle its stall bit is 0, and is then neither lost nor applied twice.
- R6: A read returns the value of the youngest queued entry whose index matches. If no entry matches, it returns the array entry.
- R7: Write-backs to the same index take effect in acceptance order, with lower pipeline numbers first within one cycle. Once the queue has drained, every register holds its last accepted value.
- R8: Synchronous active-high reset empties the queue, so no pipeline is stalled after it, and leaves the array contents unchanged.
- R9: The two read ports are independent, and each returns the R6 value for its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wb_valid | input | 3 | Write-back request per pipeline, bit 0 highest priority |
| wb_idx | input | 3x5 | Destination register index per pipeline |
| wb_data | input | 3x64 | Write-back data per pipeline |
| wb_stall | output | 3 | Pipeline must hold its write-back this cycle |
| rd_idx | input | 2x5 | Register index per read port |
| rd_data | output | 2x64 | Newest value of the indexed register per read port |

## Verification
The assertions check the port-selection rules on every cycle: a direct write whenever the queue is empty and a request is present, a drain whenever it is not, and no stall on an empty queue. They also check that pipeline 0 is never stalled, that stalls fall on a suffix of the valid pipelines, that stalled requests stay stable, and that reset leaves an empty queue. Whether the data is right can only be shown by the bench's scenarios. These cover forwarding of the youngest queued match, program order among same-index writes that pass through both the queue and the array, and the absence of lost or duplicated write-backs under random contention. They also cover preservation of the array across reset. The bench keeps a model of architectural register state and compares it on both read ports.

// File: rtl/rfwb_pkg.sv
package rfwb_pkg;

  // Slots that incoming write-backs may claim this cycle.
  // An empty queue offers all of its storage; otherwise the drained head frees one.
  function automatic int open_slots(input int fill, input int depth);
    if (fill == 0) return depth;
    return depth - fill + 1;
  endfunction

  // Queue fill after one cycle of draining and appending.
  function automatic int next_fill(input int fill, input bit pop, input int appended);
    return fill - (pop ? 1 : 0) + appended;
  endfunction

endpackage

// File: rtl/wb_slot_alloc.sv
module wb_slot_alloc #(
  parameter int NP    = 3,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input  logic [NP-1:0] req,
  input  logic [CW-1:0] fill,
  output logic [NP-1:0] direct,
  output logic [NP-1:0] append,
  output logic [NP-1:0] stall,
  output logic          drain
);

  int  room;
  int  used;
  logic taken;

  assign drain = (fill != '0);

  always_comb begin
    direct = '0;
    append = '0;
    stall  = '0;
    used   = 0;
    taken  = 1'b0;
    room   = rfwb_pkg::open_slots(int'(fill), DEPTH);
    for (int i = 0; i < NP; i++) begin
      if (req[i]) begin
        if (!drain && !taken) begin
          direct[i] = 1'b1;
          taken     = 1'b1;
        end else if (used < room) begin
          append[i] = 1'b1;
          used      = used + 1;
        end else begin
          stall[i] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wb_hold_queue.sv
module wb_hold_queue #(
  parameter int NP    = 3,
  parameter int DEPTH = 4,
  parameter int IW    = 5,
  parameter int DW    = 64,
  parameter int CW    = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NP-1:0]            append,
  input  logic [NP-1:0][IW-1:0]    in_idx,
  input  logic [NP-1:0][DW-1:0]    in_data,
  input  logic                     pop,
  output logic [CW-1:0]            fill,
  output logic [DEPTH-1:0]         ent_vld,
  output logic [DEPTH-1:0][IW-1:0] ent_idx,
  output logic [DEPTH-1:0][DW-1:0] ent_data
);

  // Entry 0 is the oldest; a pop shifts everything down by one.
  logic [CW-1:0]            fill_q;
  logic [DEPTH-1:0][IW-1:0] idx_q,  idx_n;
  logic [DEPTH-1:0][DW-1:0] data_q, data_n;
  int                       base;
  int                       rank;
  int                       fill_n;

  always_comb begin
    idx_n  = idx_q;
    data_n = data_q;
    if (pop) begin
      for (int j = 0; j < DEPTH - 1; j++) begin
        idx_n[j]  = idx_q[j+1];
        data_n[j] = data_q[j+1];
      end
    end
    base = int'(fill_q) - (pop ? 1 : 0);
    rank = 0;
    for (int i = 0; i < NP; i++) begin
      if (append[i]) begin
        for (int j = 0; j < DEPTH; j++) begin
          if (j == base + rank) begin
            idx_n[j]  = in_idx[i];
            data_n[j] = in_data[i];
          end
        end
        rank = rank + 1;
      end
    end
    fill_n = rfwb_pkg::next_fill(int'(fill_q), pop, rank);
  end

  always_ff @(posedge clk) begin
    if (rst) fill_q <= '0;
    else     fill_q <= CW'(fill_n);
  end

  always_ff @(posedge clk) begin
    idx_q  <= idx_n;
    data_q <= data_n;
  end

  generate
    for (genvar j = 0; j < DEPTH; j++) begin : g_vld
      assign ent_vld[j] = (CW'(j) < fill_q);
    end
  endgenerate

  assign fill     = fill_q;
  assign ent_idx  = idx_q;
  assign ent_data = data_q;

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int NREG = 32,
  parameter int DW   = 64,
  parameter int IW   = 5,
  parameter int NRD  = 2
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [IW-1:0]         waddr,
  input  logic [DW-1:0]         wdata,
  input  logic [NRD-1:0][IW-1:0] raddr,
  output logic [NRD-1:0][DW-1:0] rdata
);

  logic [DW-1:0] cells [NREG];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata[p] = cells[raddr[p]];
    end
  endgenerate

endmodule

// File: rtl/rf_wb_arbiter.sv
module rf_wb_arbiter #(
  parameter  int NP    = 3,
  parameter  int NREG  = 32,
  parameter  int DW    = 64,
  parameter  int DEPTH = 4,
  parameter  int NRD   = 2,
  localparam int IW    = $clog2(NREG),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NP-1:0]          wb_valid,
  input  logic [NP-1:0][IW-1:0]  wb_idx,
  input  logic [NP-1:0][DW-1:0]  wb_data,
  output logic [NP-1:0]          wb_stall,
  input  logic [NRD-1:0][IW-1:0] rd_idx,
  output logic [NRD-1:0][DW-1:0] rd_data
);

  // Internal events, named for the checker.
  logic [NP-1:0]            direct;
  logic [NP-1:0]            append;
  logic                     drain;
  logic [CW-1:0]            fill;
  logic                     wr_en;
  logic [IW-1:0]            wr_idx;
  logic [DW-1:0]            wr_data;
  logic [DEPTH-1:0]         ent_vld;
  logic [DEPTH-1:0][IW-1:0] ent_idx;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic [NRD-1:0][DW-1:0]   arr_rd;

  wb_slot_alloc #(.NP(NP), .DEPTH(DEPTH), .CW(CW)) u_alloc (
    .req    (wb_valid),
    .fill   (fill),
    .direct (direct),
    .append (append),
    .stall  (wb_stall),
    .drain  (drain)
  );

  wb_hold_queue #(.NP(NP), .DEPTH(DEPTH), .IW(IW), .DW(DW), .CW(CW)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .append   (append),
    .in_idx   (wb_idx),
    .in_data  (wb_data),
    .pop      (drain),
    .fill     (fill),
    .ent_vld  (ent_vld),
    .ent_idx  (ent_idx),
    .ent_data (ent_data)
  );

  always_comb begin
    wr_idx  = ent_idx[0];
    wr_data = ent_data[0];
    if (!drain) begin
      for (int i = NP - 1; i >= 0; i--) begin
        if (direct[i]) begin
          wr_idx  = wb_idx[i];
          wr_data = wb_data[i];
        end
      end
    end
  end

  assign wr_en = drain | (|direct);

  rf_storage #(.NREG(NREG), .DW(DW), .IW(IW), .NRD(NRD)) u_array (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (wr_data),
    .raddr (rd_idx),
    .rdata (arr_rd)
  );

  // Forwarding: later (younger) matching entries override earlier ones.
  generate
    for (genvar p = 0; p < NRD; p++) begin : g_fwd
      logic          hit;
      logic [DW-1:0] fwd;
      always_comb begin
        hit = 1'b0;
        fwd = '0;
        for (int j = 0; j < DEPTH; j++) begin
          if (ent_vld[j] && ent_idx[j] == rd_idx[p]) begin
            hit = 1'b1;
            fwd = ent_data[j];
          end
        end
        rd_data[p] = hit ? fwd : arr_rd[p];
      end
    end
  endgenerate

endmodule

// File: rtl/rf_wb_arbiter_chk.sv
module rf_wb_arbiter_chk #(
  parameter int NP    = 3,
  parameter int DEPTH = 4,
  parameter int IW    = 5,
  parameter int DW    = 64,
  parameter int CW    = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NP-1:0]         wb_valid,
  input logic [NP-1:0][IW-1:0] wb_idx,
  input logic [NP-1:0][DW-1:0] wb_data,
  input logic [NP-1:0]         wb_stall,
  input logic [CW-1:0]         fill,
  input logic                  drain,
  input logic                  wr_en
);

  // R8
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> fill == '0);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(fill) <= DEPTH);

  // R1
  direct_write_chk: assert property (@(posedge clk) disable iff (rst)
    (fill == '0 && wb_valid != '0) |-> (wr_en && !drain));

  // R3
  head_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (fill != '0) |-> (wr_en && drain));

  // R2
  empty_nostall_chk: assert property (@(posedge clk) disable iff (rst)
    (fill == '0) |-> wb_stall == '0);

  // R4
  top_free_chk: assert property (@(posedge clk) disable iff (rst)
    !wb_stall[0]);

  generate
    for (genvar i = 0; i < NP; i++) begin : g_pipe
      // R4
      stall_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        wb_stall[i] |-> wb_valid[i]);
      // R5
      hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wb_stall[i]) |-> (wb_valid[i] && $stable(wb_idx[i]) && $stable(wb_data[i])));
      if (i + 1 < NP) begin : g_suffix
        // R4
        stall_suffix_chk: assert property (@(posedge clk) disable iff (rst)
          (wb_stall[i] && wb_valid[i+1]) |-> wb_stall[i+1]);
      end
    end
  endgenerate

endmodule

bind rf_wb_arbiter rf_wb_arbiter_chk #(.NP(NP), .DEPTH(DEPTH), .IW(IW), .DW(DW), .CW(CW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .wb_valid (wb_valid),
  .wb_idx   (wb_idx),
  .wb_data  (wb_data),
  .wb_stall (wb_stall),
  .fill     (fill),
  .drain    (drain),
  .wr_en    (wr_en)
);

// File: tb/rf_wb_arbiter_test.sv
module rf_wb_arbiter_test;

  localparam int CLK_P = 10;
  localparam int NP    = 3;
  localparam int NREG  = 32;
  localparam int DW    = 64;
  localparam int DEPTH = 4;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [2:0]          wb_valid = '0;
  logic [2:0][4:0]     wb_idx   = '0;
  logic [2:0][63:0]    wb_data  = '0;
  logic [2:0]          wb_stall;
  logic [1:0][4:0]     rd_idx   = '0;
  logic [1:0][63:0]    rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [63:0] model [NREG];
  bit          known [NREG];
  int          fill_m = 0;
  logic [2:0]  last_stall = '0;
  int          seq = 0;

  rf_wb_arbiter #(.NP(NP), .NREG(NREG), .DW(DW), .DEPTH(DEPTH), .NRD(2)) uut (
    .clk(clk), .rst(rst), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .wb_stall(wb_stall), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always #(CLK_P/2) clk = ~clk;

  // Expected stall pattern from the slot rule.
  function automatic logic [2:0] want_stall(logic [2:0] v, int f);
    int room = DEPTH - f + 1;
    int seen = 0;
    logic [2:0] s = '0;
    if (f == 0) return '0;
    for (int i = 0; i < 3; i++)
      if (v[i]) begin
        if (seen >= room) s[i] = 1'b1;
        seen++;
      end
    return s;
  endfunction

  function automatic int after_fill(logic [2:0] v, int f);
    int n = $countones(v);
    int room = DEPTH - f + 1;
    if (f == 0) return (n > 0) ? n - 1 : 0;
    return f - 1 + ((n < room) ? n : room);
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check3(string tag, logic [2:0] act, logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One cycle: offer new write-backs on free pipes, check stalls and reads, update model.
  task automatic run_cycle(logic [2:0] offer, logic [4:0] i0, logic [4:0] i1, logic [4:0] i2,
                           logic [4:0] r0, logic [4:0] r1, string rtag);
    logic [4:0] ni [3];
    logic [2:0] exp_s;
    logic [2:0] acc;
    ni[0] = i0; ni[1] = i1; ni[2] = i2;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      if (!(wb_valid[i] && last_stall[i])) begin
        if (offer[i]) begin
          seq++;
          wb_valid[i] = 1'b1;
          wb_idx[i]   = ni[i];
          wb_data[i]  = {8'(i), 24'h0, 32'(seq)};
        end else begin
          wb_valid[i] = 1'b0;
        end
      end
    end
    rd_idx[0] = r0;
    rd_idx[1] = r1;
    #1;
    exp_s = want_stall(wb_valid, fill_m);
    check3((fill_m == 0) ? "R2 stall" : "R4 stall", wb_stall, exp_s);
    if (known[r0]) check64(rtag, rd_data[0], model[r0]);
    if (known[r1]) check64("R9 port1", rd_data[1], model[r1]);
    last_stall = wb_stall;
    acc = wb_valid & ~wb_stall;
    for (int i = 0; i < 3; i++)
      if (acc[i]) begin
        model[wb_idx[i]] = wb_data[i];
        known[wb_idx[i]] = 1'b1;
      end
    fill_m = after_fill(acc, fill_m);
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wb_valid = '0;
    last_stall = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    fill_m = 0;
  endtask

  task automatic read_all(string tag);
    for (int r = 0; r < NREG; r++)
      run_cycle(3'b000, 0, 0, 0, 5'(r), 5'(NREG - 1 - r), tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int r = 0; r < NREG; r++) known[r] = 1'b0;
    do_reset();
    // R8: empty queue after reset, so no stall even with all pipes valid
    run_cycle(3'b111, 5'd1, 5'd2, 5'd3, 5'd0, 5'd0, "R8 read");
    run_cycle(3'b000, 0, 0, 0, 5'd1, 5'd2, "R2 read");
    repeat (3) run_cycle(3'b000, 0, 0, 0, 5'd3, 5'd2, "R3 read");
    // R1: one direct write per cycle, read back the next cycle
    for (int r = 0; r < NREG; r++)
      run_cycle(3'b001, 5'(r), 0, 0, 5'(r == 0 ? 0 : r - 1), 5'd1, "R1 direct read");
    // R7: three same-index write-backs in one cycle, then while queue is busy
    run_cycle(3'b111, 5'd9, 5'd9, 5'd9, 5'd9, 5'd9, "R7 read");
    run_cycle(3'b111, 5'd9, 5'd9, 5'd9, 5'd9, 5'd9, "R6 youngest match");
    run_cycle(3'b111, 5'd9, 5'd9, 5'd9, 5'd9, 5'd9, "R6 youngest match");
    repeat (8) run_cycle(3'b000, 0, 0, 0, 5'd9, 5'd4, "R7 after drain");
    // R4/R5: saturate the queue with distinct indices
    for (int k = 0; k < 12; k++)
      run_cycle(3'b111, 5'(k), 5'(k + 10), 5'(k + 20), 5'(k + 20), 5'(k), "R5 held write");
    repeat (8) run_cycle(3'b000, 0, 0, 0, 5'd21, 5'd11, "R5 after drain");
    // Random phases: light load full range, heavy load narrow range
    for (int ph = 0; ph < 3; ph++) begin
      for (int c = 0; c < 1500; c++) begin
        logic [2:0] off;
        logic [4:0] msk;
        int pct;
        pct = (ph == 0) ? 30 : (ph == 1) ? 85 : 60;
        msk = (ph == 1) ? 5'h07 : 5'h1f;
        for (int i = 0; i < 3; i++) off[i] = (($urandom % 100) < pct);
        run_cycle(off, 5'($urandom) & msk, 5'($urandom) & msk, 5'($urandom) & msk,
                  5'($urandom) & msk, 5'($urandom) & msk, "R6 random read");
      end
    end
    repeat (8) run_cycle(3'b000, 0, 0, 0, 5'd0, 5'd1, "R7 drain read");
    read_all("R7 final state");
    do_reset();
    read_all("R8 kept after reset");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule